// File: doc/BRIEF.md
# Transceiver Status Interrupt Latch

This block gathers eight status conditions from a USB On-the-Go transceiver front end. Two are composite. The session-end/D+ flag is the OR of two comparator outputs. The disconnect-reconnect flag is the AND of an enable and an event input. The eight conditions are registered into a read-only source register. Each source bit drives a sticky latch bit. A latch bit is set when its source makes a transition that software has enabled. Rising and falling transitions are enabled separately, through two enable registers.

Software sees a small address/data register port. Reads have one cycle of latency. Writes to one address set latch bits. Writes to another address clear them. In both cases only the bits written as 1 are affected. A single active-high interrupt output is asserted while any latch bit is set.

Top module: `otg_irq_latch`

## Requirements
- R1: After reset, the latch register, both enable registers, the read data and the interrupt output are all 0.
- R2: Reading address 08h returns the source register. Bit 0 is VBUS valid, bit 1 is session valid, bit 2 is D+ high and bit 3 is ID grounded. Bit 4 is D- high and bit 5 is ID open. Bit 6 is the AND of the disconnect-reconnect enable and event inputs. Bit 7 is the OR of the session-end and D+ interrupt comparators. The register shows the inputs one clock after they are applied.
- R3: A write to address 08h changes neither the latch register nor either enable register.
- R4: A 0-to-1 transition of a source bit sets its latch bit when the matching bit of the rising-enable register (0Ch) is 1.
- R5: A 1-to-0 transition of a source bit sets its latch bit when the matching bit of the falling-enable register (0Dh) is 1.
- R6: A source transition whose matching enable bit is 0 leaves the latch bit unchanged.
- R7: A write to 0Ah sets every latch bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R8: A write to 0Bh clears every latch bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R9: When a clear write and an enabled transition hit the same latch bit in the same cycle, the bit ends up set.
- R10: The interrupt output is the OR of the latch bits. It stays at 1 until the last set bit has been cleared.
- R11: The enable registers read back at 0Ch and 0Dh. The latch register reads back at 0Ah. Read data appears one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_valid_i | input | 1 | VBUS valid comparator |
| sess_valid_i | input | 1 | Session valid comparator |
| dp_high_i | input | 1 | D+ high comparator |
| id_ground_i | input | 1 | ID pin grounded |
| dm_high_i | input | 1 | D- high comparator |
| id_open_i | input | 1 | ID pin floating |
| disc_acon_en_i | input | 1 | Disconnect-reconnect enable |
| disc_acon_evt_i | input | 1 | Pull-up asserted after B-device disconnect |
| sess_end_cmp_i | input | 1 | Session-end comparator |
| dp_int_cmp_i | input | 1 | D+ interrupt comparator |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The bench fires a clear write and an enabled transition into the same latch bit in the same cycle. A design that lets the clear win would lose that event. Next to it, the bench clears a bit that has no edge, which a design that ignores the clear would miss. It raises and then drops a source whose only enabled direction is falling. A design that treats any change as an edge would latch on the rise. It writes all ones to the read-only address and reads the enables back, which catches a decoder that aliases 08h onto a writable register. Table patterns drive each composite input on its own and together, which exposes a swapped AND/OR or a misplaced bit.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;
  localparam int NSRC = 8;
  localparam logic [7:0] ADR_SRC  = 8'h08;
  localparam logic [7:0] ADR_SET  = 8'h0A;
  localparam logic [7:0] ADR_CLR  = 8'h0B;
  localparam logic [7:0] ADR_RISE = 8'h0C;
  localparam logic [7:0] ADR_FALL = 8'h0D;
endpackage

// File: rtl/otg_irq_edge.sv
module otg_irq_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] src_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      prev_q <= '0;
    end else begin
      src_q  <= raw_i;
      prev_q <= src_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = src_q[i] & ~prev_q[i];
    assign fall_o[i] = ~src_q[i] & prev_q[i];
  end

  assign src_o = src_q;

  // R4
  prev_tracks_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prev_q == $past(src_q));
endmodule

// File: rtl/otg_irq_core.sv
module otg_irq_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic         wr_rise_i,
  input  logic         wr_fall_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_rise_o,
  output logic [W-1:0] en_fall_o,
  output logic [W-1:0] latch_o,
  output logic         irq_o
);
  logic [W-1:0] en_rise_q, en_fall_q, latch_q, latch_d;
  logic [W-1:0] hit, set_m, clr_m;
  logic         irq_q;

  assign hit   = (rise_i & en_rise_q) | (fall_i & en_fall_q);
  assign set_m = wr_set_i ? wdata_i : '0;
  assign clr_m = wr_clr_i ? wdata_i : '0;
  assign latch_d = ((latch_q | set_m) & ~clr_m) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_rise_q <= '0;
      en_fall_q <= '0;
      latch_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_rise_i) en_rise_q <= wdata_i;
      if (wr_fall_i) en_fall_q <= wdata_i;
      latch_q <= latch_d;
      irq_q   <= |latch_d;
    end
  end

  assign en_rise_o = en_rise_q;
  assign en_fall_o = en_fall_q;
  assign latch_o   = latch_q;
  assign irq_o     = irq_q;

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((latch_q & ~$past(latch_q)) & ~($past(set_m) | $past(hit))) == '0);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (latch_q & $past(clr_m) & ~$past(hit)) == '0);
  // R10
  irq_matches_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|latch_q));
  // R3
  rise_en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_rise_i |=> $stable(en_rise_q));
  // R3
  fall_en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_fall_i |=> $stable(en_fall_q));
endmodule

// File: rtl/otg_irq_latch.sv
module otg_irq_latch
  import otg_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vbus_valid_i,
  input  logic              sess_valid_i,
  input  logic              dp_high_i,
  input  logic              id_ground_i,
  input  logic              dm_high_i,
  input  logic              id_open_i,
  input  logic              disc_acon_en_i,
  input  logic              disc_acon_evt_i,
  input  logic              sess_end_cmp_i,
  input  logic              dp_int_cmp_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0] raw, src, rise, fall, en_rise, en_fall, latch;
  logic [NSRC-1:0] rdata_q;
  logic wr_rise, wr_fall, wr_set, wr_clr;

  assign raw = {sess_end_cmp_i | dp_int_cmp_i,
                disc_acon_en_i & disc_acon_evt_i,
                id_open_i, dm_high_i, id_ground_i,
                dp_high_i, sess_valid_i, vbus_valid_i};

  assign wr_set  = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_SET));
  assign wr_clr  = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CLR));
  assign wr_rise = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_RISE));
  assign wr_fall = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_FALL));

  otg_irq_edge #(.W(NSRC)) edge_i (
    .clk(clk), .rst(rst), .raw_i(raw),
    .src_o(src), .rise_o(rise), .fall_o(fall)
  );

  otg_irq_core #(.W(NSRC)) core_i (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
    .wr_rise_i(wr_rise), .wr_fall_i(wr_fall),
    .wr_set_i(wr_set), .wr_clr_i(wr_clr), .wdata_i(reg_wdata_i),
    .en_rise_o(en_rise), .en_fall_o(en_fall),
    .latch_o(latch), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      if (reg_addr_i == ADDR_W'(ADR_SRC))       rdata_q <= src;
      else if (reg_addr_i == ADDR_W'(ADR_SET))  rdata_q <= latch;
      else if (reg_addr_i == ADDR_W'(ADR_RISE)) rdata_q <= en_rise;
      else if (reg_addr_i == ADDR_W'(ADR_FALL)) rdata_q <= en_fall;
      else                                      rdata_q <= '0;
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: tb/otg_irq_latch_tb.sv
`timescale 1ns/1ps
module otg_irq_latch_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] raw = '0;
  logic wr = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  otg_irq_latch dut_i (
    .clk(clk), .rst(rst),
    .vbus_valid_i(raw[0]), .sess_valid_i(raw[1]), .dp_high_i(raw[2]),
    .id_ground_i(raw[3]), .dm_high_i(raw[4]), .id_open_i(raw[5]),
    .disc_acon_en_i(raw[6]), .disc_acon_evt_i(raw[7]),
    .sess_end_cmp_i(raw[8]), .dp_int_cmp_i(raw[9]),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // upper 10 bits: raw inputs, lower 8: expected source register (R2)
  localparam logic [17:0] VEC [10] = '{
    {10'h000, 8'h00}, {10'h001, 8'h01}, {10'h03F, 8'h3F}, {10'h040, 8'h00},
    {10'h080, 8'h00}, {10'h0C0, 8'h40}, {10'h100, 8'h80}, {10'h200, 8'h80},
    {10'h300, 8'h80}, {10'h2AA, 8'hAA}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = 8'h00;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); wr = 1'b0; addr = a;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic drive(input logic [9:0] v);
    @(negedge clk); raw = v;
    idle(3);
  endtask

  initial begin
    #1000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 rdata", rdata, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rreg(8'h0A, v); check("R1 latch", v, 8'h00);
    rreg(8'h0C, v); check("R1 rise_en", v, 8'h00);

    // R2 table walk, enables 0 so nothing latches
    for (int k = 0; k < 10; k++) begin
      drive(VEC[k][17:8]);
      rreg(8'h08, v);
      check("R2 source map", v, VEC[k][7:0]);
    end
    drive(10'h000);
    rreg(8'h0A, v); check("R6 no enable no latch", v, 8'h00);

    // R11 enable readback
    wreg(8'h0C, 8'h01);
    wreg(8'h0D, 8'h02);
    rreg(8'h0C, v); check("R11 rise_en readback", v, 8'h01);
    rreg(8'h0D, v); check("R11 fall_en readback", v, 8'h02);

    // R4 rising edge
    drive(10'h001);
    rreg(8'h0A, v); check("R4 rise latched", v, 8'h01);
    check("R10 irq high", {7'b0, irq}, 8'h01);
    // R6 rise on falling-only bit
    drive(10'h003);
    rreg(8'h0A, v); check("R6 rise not enabled", v, 8'h01);
    // R5 falling edge
    drive(10'h001);
    rreg(8'h0A, v); check("R5 fall latched", v, 8'h03);

    // R3 write to source address
    wreg(8'h08, 8'hFF);
    rreg(8'h0A, v); check("R3 latch untouched", v, 8'h03);
    rreg(8'h0C, v); check("R3 rise_en untouched", v, 8'h01);
    rreg(8'h0D, v); check("R3 fall_en untouched", v, 8'h02);

    // R8 / R10 clear one at a time
    wreg(8'h0B, 8'h01);
    rreg(8'h0A, v); check("R8 clear bit0", v, 8'h02);
    check("R10 irq held", {7'b0, irq}, 8'h01);
    wreg(8'h0B, 8'h02);
    rreg(8'h0A, v); check("R8 clear bit1", v, 8'h00);
    check("R10 irq drops", {7'b0, irq}, 8'h00);

    // R7 set writes
    wreg(8'h0A, 8'hA5);
    rreg(8'h0A, v); check("R7 set", v, 8'hA5);
    check("R10 irq after set", {7'b0, irq}, 8'h01);
    wreg(8'h0A, 8'h00);
    rreg(8'h0A, v); check("R7 zero leaves", v, 8'hA5);
    wreg(8'h0B, 8'h00);
    rreg(8'h0A, v); check("R8 zero leaves", v, 8'hA5);
    wreg(8'h0B, 8'hA5);

    // R9 edge beats clear in same cycle
    drive(10'h000);
    wreg(8'h0A, 8'h03);
    @(negedge clk); raw = 10'h001;
    @(negedge clk); wr = 1'b1; addr = 8'h0B; wdata = 8'h03;
    @(negedge clk); wr = 1'b0; addr = 8'h00;
    rreg(8'h0A, v); check("R9 edge wins over clear", v, 8'h01);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0; raw = 10'h000;
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    rreg(8'h0A, v); check("R1 latch after reset", v, 8'h00);
    rreg(8'h0D, v); check("R1 fall_en after reset", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule